// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block produces the reset for a processor from two causes. The first is a digital undervoltage flag that is already in the block's clock domain. The second is a watchdog that the processor must service by toggling an input. Reset comes out in two polarities. An internal service-pulse output shows when the block has serviced the watchdog itself. The reset hold-off length and the watchdog base length are inputs, both counted in clock cycles.

The watchdog has two lengths, selected by a mode input: the base length, or 500 times the base length. In the long mode a second input can report that the service line is left floating. The block then services the watchdog itself at 15/16 of the period, which in effect switches the watchdog off. A base length of zero disables the watchdog altogether.

The block is built around three states:
- `ST_UNDERVOLT`: the flag is set.
- `ST_HOLDOFF`: the hold-off count is running.
- `ST_RUN`: reset is released.

The transitions are:
- undervolt-enter: any state to `ST_UNDERVOLT` when the flag is set.
- flag-clear: `ST_UNDERVOLT` to `ST_HOLDOFF`.
- holdoff-done: `ST_HOLDOFF` to `ST_RUN`.
- dog-expire: `ST_RUN` to `ST_HOLDOFF`.
- power-on entry: the synchronous power-on reset puts the block into `ST_HOLDOFF`.

Top module: `por_wdt_supervisor`

## Requirements
- R1: A set undervoltage flag sampled at a clock edge makes `cpu_rst_n` low after that edge. It stays low for as long as the flag stays set.
- R2: When the flag clears, the first edge that samples it low starts the hold-off. `cpu_rst_n` rises after P further edges, where P is `rst_period`. A P of 0 acts as 1, so the release comes on the 2nd edge.
- R3: While `rst_n` is low, `cpu_rst_n` is low. After `rst_n` is released, `cpu_rst_n` rises on the P-th clock edge.
- R4: The watchdog count is zero whenever reset has been asserted for more than one cycle. Without service, reset asserts on the L-th edge after release, where L is the effective period. It then releases P edges later, and this cycle repeats.
- R5: A rising or a falling change on `svc_in` restarts the watchdog count from zero on the 3rd edge after the change. The timeout then falls L edges later, which is L+3 edges after the change.
- R6: Any change on `ext_mode` restarts the watchdog count in the same way. The timeout then falls L+3 edges after the change, using the new period.
- R7: With `ext_mode` = 1, L is 500 × `wd_base`. With `ext_mode` = 0, L is `wd_base`.
- R8: With `ext_mode` = 1 and `svc_float` = 1, `svc_pulse` is high for one cycle when the count equals (L×15)>>4, and the count restarts on the next edge, so no timeout occurs. With `ext_mode` = 0, `svc_float` has no effect and timeouts still occur.
- R9: With `wd_base` = 0, the watchdog never asserts reset. Undervoltage reset still works.
- R10: `cpu_rst` is always the inverse of `cpu_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| uv_flag | input | 1 | Supply below threshold (already synchronous) |
| svc_in | input | 1 | Watchdog service input, either edge services |
| ext_mode | input | 1 | 1 selects the 500x watchdog period |
| svc_float | input | 1 | Service input is reported as floating |
| rst_period | input | RP_W | Reset hold-off length in cycles |
| wd_base | input | WD_W | Watchdog base period in cycles, 0 disables |
| cpu_rst_n | output | 1 | Processor reset, active low |
| cpu_rst | output | 1 | Processor reset, active high |
| svc_pulse | output | 1 | Internal self-service pulse |

## Verification
Some properties hold on every cycle and are checked that way:
- the one-edge response to the undervoltage flag;
- the output polarity pair;
- the count staying at zero while reset is held;
- the count restarting after a service edge, a mode edge or a self-service pulse;
- no timeout while the base period is zero.

Exact cycle lengths can only be shown by the directed scenarios:
- the hold-off, including the zero case;
- the normal and 500x timeouts;
- the three-edge synchronizer latency of service and mode edges;
- the position of the self-service pulse;
- the repeating reset string.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        ST_UNDERVOLT = 2'd0,
        ST_HOLDOFF   = 2'd1,
        ST_RUN       = 2'd2
    } sup_state_t;

    localparam int unsigned EXT_MULT = 500;
    localparam int unsigned EXT_BITS = 9;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog import sup_pkg::*; #(
    parameter int WD_W = 16,
    localparam int CW  = WD_W + EXT_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            svc_s,
    input  logic            mode_s,
    input  logic            float_s,
    input  logic [WD_W-1:0] base,
    output logic            expire,
    output logic            svc_pulse,
    output logic [CW-1:0]   cnt_o,
    output logic            svc_edge,
    output logic            mode_edge
);
    logic          svc_q, mode_q;
    logic [CW-1:0] cnt, limit, thr, base_w;
    logic [CW+3:0] scaled;
    logic          en, restart;

    assign base_w = CW'(base);
    assign limit  = mode_s ? base_w * CW'(EXT_MULT) : base_w;
    assign scaled = (CW+4)'(limit) * (CW+4)'(15);
    assign thr    = scaled[CW+3:4];
    assign en     = |base;

    assign svc_edge  = svc_s ^ svc_q;
    assign mode_edge = mode_s ^ mode_q;

    assign svc_pulse = !hold && en && mode_s && float_s && (cnt == thr);
    assign restart   = svc_edge || mode_edge || svc_pulse;
    assign expire    = !hold && en && !restart && (cnt >= limit - CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_q  <= 1'b0;
            mode_q <= 1'b0;
            cnt    <= '0;
        end else begin
            svc_q  <= svc_s;
            mode_q <= mode_s;
            if (hold || restart || expire || !en)
                cnt <= '0;
            else
                cnt <= cnt + CW'(1);
        end
    end

    assign cnt_o = cnt;
endmodule

// File: rtl/sup_fsm.sv
module sup_fsm import sup_pkg::*; #(
    parameter int RP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            uv,
    input  logic            wd_expire,
    input  logic [RP_W-1:0] period,
    output logic            run
);
    localparam logic [RP_W:0] ONE = (RP_W+1)'(1);

    sup_state_t      state, state_nx;
    logic [RP_W-1:0] hcnt, hcnt_nx;
    logic            hold_done;

    assign hold_done = ({1'b0, hcnt} + ONE) >= {1'b0, period};

    always_comb begin
        state_nx = state;
        hcnt_nx  = hcnt;
        unique case (state)
            ST_UNDERVOLT: begin
                if (!uv) begin
                    state_nx = ST_HOLDOFF;
                    hcnt_nx  = '0;
                end
            end
            ST_HOLDOFF: begin
                if (uv) begin
                    state_nx = ST_UNDERVOLT;
                end else if (hold_done) begin
                    state_nx = ST_RUN;
                    hcnt_nx  = '0;
                end else begin
                    hcnt_nx  = hcnt + RP_W'(1);
                end
            end
            ST_RUN: begin
                if (uv) begin
                    state_nx = ST_UNDERVOLT;
                end else if (wd_expire) begin
                    state_nx = ST_HOLDOFF;
                    hcnt_nx  = '0;
                end
            end
            default: begin
                state_nx = ST_HOLDOFF;
                hcnt_nx  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HOLDOFF;
            hcnt  <= '0;
        end else begin
            state <= state_nx;
            hcnt  <= hcnt_nx;
        end
    end

    always_comb begin
        run = (state == ST_RUN);
    end
endmodule

// File: rtl/por_wdt_supervisor.sv
module por_wdt_supervisor import sup_pkg::*; #(
    parameter int RP_W = 16,
    parameter int WD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            uv_flag,
    input  logic            svc_in,
    input  logic            ext_mode,
    input  logic            svc_float,
    input  logic [RP_W-1:0] rst_period,
    input  logic [WD_W-1:0] wd_base,
    output logic            cpu_rst_n,
    output logic            cpu_rst,
    output logic            svc_pulse
);
    localparam int CNT_W = WD_W + EXT_BITS;

    logic [2:0]       raw_in, sync_in;
    logic             run, wd_expire, svc_edge, mode_edge;
    logic [CNT_W-1:0] wd_cnt;

    assign raw_in = {svc_float, ext_mode, svc_in};

    sup_sync #(.N(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_in)
    );

    sup_wdog #(.WD_W(WD_W)) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (!run),
        .svc_s     (sync_in[0]),
        .mode_s    (sync_in[1]),
        .float_s   (sync_in[2]),
        .base      (wd_base),
        .expire    (wd_expire),
        .svc_pulse (svc_pulse),
        .cnt_o     (wd_cnt),
        .svc_edge  (svc_edge),
        .mode_edge (mode_edge)
    );

    sup_fsm #(.RP_W(RP_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .uv        (uv_flag),
        .wd_expire (wd_expire),
        .period    (rst_period),
        .run       (run)
    );

    assign cpu_rst_n = run;
    assign cpu_rst   = !run;
endmodule

// File: rtl/por_wdt_sva.sv
module por_wdt_sva #(
    parameter int WD_W = 16,
    parameter int CW   = 25
) (
    input logic            clk,
    input logic            rst_n,
    input logic            uv_flag,
    input logic [WD_W-1:0] wd_base,
    input logic            cpu_rst_n,
    input logic            cpu_rst,
    input logic            svc_pulse,
    input logic [CW-1:0]   wd_cnt,
    input logic            svc_edge,
    input logic            mode_edge
);
    a_r1_uv_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> !cpu_rst_n);

    a_r10_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst != cpu_rst_n);

    a_r4_wd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rst_n && $past(!cpu_rst_n)) |-> (wd_cnt == '0));

    a_r5_edge_restart: assert property (@(posedge clk) disable iff (!rst_n)
        svc_edge |=> (wd_cnt == '0));

    a_r6_mode_restart: assert property (@(posedge clk) disable iff (!rst_n)
        mode_edge |=> (wd_cnt == '0));

    a_r8_pulse_restart: assert property (@(posedge clk) disable iff (!rst_n)
        svc_pulse |=> (wd_cnt == '0));

    a_r9_base_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_base == '0 && !uv_flag && cpu_rst_n) |=> cpu_rst_n);
endmodule

bind por_wdt_supervisor por_wdt_sva #(.WD_W(WD_W), .CW(CNT_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .uv_flag   (uv_flag),
    .wd_base   (wd_base),
    .cpu_rst_n (cpu_rst_n),
    .cpu_rst   (cpu_rst),
    .svc_pulse (svc_pulse),
    .wd_cnt    (wd_cnt),
    .svc_edge  (svc_edge),
    .mode_edge (mode_edge)
);

// File: tb/por_wdt_supervisor_tb.sv
module por_wdt_supervisor_tb;
    localparam int RP_W = 16;
    localparam int WD_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            uv = 1'b0, svc = 1'b0, mode = 1'b0, flt = 1'b0;
    logic [RP_W-1:0] per = 16'd10;
    logic [WD_W-1:0] base = 16'd20;
    logic            cpu_rst_n, cpu_rst, svc_pulse;

    int checks = 0, errors = 0, inv_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    por_wdt_supervisor #(.RP_W(RP_W), .WD_W(WD_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .uv_flag    (uv),
        .svc_in     (svc),
        .ext_mode   (mode),
        .svc_float  (flt),
        .rst_period (per),
        .wd_base    (base),
        .cpu_rst_n  (cpu_rst_n),
        .cpu_rst    (cpu_rst),
        .svc_pulse  (svc_pulse)
    );

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
        if (cpu_rst !== ~cpu_rst_n) inv_bad++;
    endtask

    task automatic por();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_eq("R3 reset low during power-on reset", int'(cpu_rst_n), 0);
        chk_eq("R10 high output during power-on reset", int'(cpu_rst), 1);
        rst_n = 1'b1;
    endtask

    task automatic edges_until(input logic v, input int maxn, output int n);
        n = 0;
        while (cpu_rst_n !== v && n < maxn) begin
            step();
            n++;
        end
    endtask

    task automatic t_por_uv();
        int n, hi;
        uv = 0; svc = 0; mode = 0; flt = 0; per = 10; base = 20;
        por();
        edges_until(1'b1, 100, n);
        chk_eq("R3 release edges after power-on reset", n, 10);
        @(negedge clk) uv = 1'b1;
        step();
        chk_eq("R1 reset after one edge", int'(cpu_rst_n), 0);
        hi = 0;
        repeat (30) begin
            step();
            if (cpu_rst_n) hi++;
        end
        chk_eq("R1 reset held while flag set", hi, 0);
        @(negedge clk) uv = 1'b0;
        edges_until(1'b1, 100, n);
        chk_eq("R2 hold-off after flag clears", n, 11);
        @(negedge clk) begin uv = 1'b1; per = 0; end
        repeat (3) @(negedge clk);
        uv = 1'b0;
        edges_until(1'b1, 100, n);
        chk_eq("R2 zero period acts as one", n, 2);
        per = 10;
    endtask

    task automatic t_wd_period();
        int n;
        uv = 0; svc = 0; mode = 0; flt = 0; base = 20;
        por();
        edges_until(1'b1, 100, n);
        edges_until(1'b0, 1000, n);
        chk_eq("R4 normal timeout length", n, 20);
        edges_until(1'b1, 100, n);
        chk_eq("R4 watchdog reset length", n, 10);
        edges_until(1'b0, 1000, n);
        chk_eq("R4 repeated timeout length", n, 20);
    endtask

    task automatic t_service();
        int n, lo;
        uv = 0; svc = 0; mode = 0; flt = 0; base = 20;
        por();
        edges_until(1'b1, 100, n);
        lo = 0;
        repeat (12) begin
            repeat (14) @(negedge clk);
            if (!cpu_rst_n) lo++;
            svc = ~svc;
        end
        chk_eq("R5 serviced watchdog never fires", lo, 0);
        edges_until(1'b0, 1000, n);
        chk_eq("R5 timeout after last service edge", n, 23);
    endtask

    task automatic t_mode();
        int n;
        uv = 0; svc = 0; mode = 1; flt = 0; base = 20;
        por();
        edges_until(1'b1, 100, n);
        repeat (100) @(negedge clk);
        chk_eq("R6 extended mode still released", int'(cpu_rst_n), 1);
        mode = 1'b0;
        edges_until(1'b0, 1000, n);
        chk_eq("R6 restart on mode change", n, 23);
    endtask

    task automatic t_ext();
        int n;
        uv = 0; svc = 0; mode = 1; flt = 0; base = 20;
        por();
        edges_until(1'b1, 100, n);
        edges_until(1'b0, 20000, n);
        chk_eq("R7 extended timeout length", n, 10000);
    endtask

    task automatic t_float();
        int n, first, pulses, lo;
        uv = 0; svc = 0; mode = 1; flt = 1; base = 20;
        por();
        edges_until(1'b1, 100, n);
        first = 0; pulses = 0; lo = 0;
        for (int k = 1; k <= 30000; k++) begin
            step();
            if (svc_pulse) begin
                pulses++;
                if (first == 0) first = k;
            end
            if (!cpu_rst_n) lo++;
        end
        chk_eq("R8 first self-service pulse position", first, 9375);
        chk_eq("R8 self-service pulse count", pulses, 3);
        chk_eq("R8 no timeout with floating input", lo, 0);
        mode = 0;
        por();
        edges_until(1'b1, 100, n);
        edges_until(1'b0, 1000, n);
        chk_eq("R8 floating input ignored in normal mode", n, 20);
    endtask

    task automatic t_base0();
        int n, lo;
        uv = 0; svc = 0; mode = 0; flt = 0; base = 0;
        por();
        edges_until(1'b1, 100, n);
        lo = 0;
        repeat (3000) begin
            step();
            if (!cpu_rst_n) lo++;
        end
        chk_eq("R9 zero base never times out", lo, 0);
        @(negedge clk) uv = 1'b1;
        step();
        chk_eq("R9 undervoltage still resets", int'(cpu_rst_n), 0);
        @(negedge clk) uv = 1'b0;
        base = 20;
    endtask

    initial begin
        t_por_uv();
        t_wd_period();
        t_service();
        t_mode();
        t_ext();
        t_float();
        t_base0();
        chk_eq("R10 outputs always inverse", inv_bad, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run limit actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule